// File: doc/BRIEF.md
# Conversion Result Block Mover

This block takes each finished conversion result from a converter and writes it as one word into a region of memory through a simple write master (address, data, one-cycle strobe). Software supplies a base address, a word count per block, a one-block or two-block layout, and a continuous option. In the two-block layout the region is split into two equal halves that fill one after the other. A processor can drain one half while the other fills. An output names the half that was filled most recently, and a one-cycle done pulse marks the last word of each block, not every word.

A count of zero keeps the mover disabled. A run starts with the first result that arrives while the mover is idle and the count is non-zero. When the continuous option is off, the mover stops after the last word of the region. It then discards further results until the count has been cleared to zero and set again. When the option is on, it wraps to the base address and carries on. Configuration changes made during a run take effect only at the end of a pass through the region.

Results arrive on a valid/ready stream. `res_ready` is low during reset and high from the first clock after reset. The mover never applies back-pressure, because each write uses the port for exactly one cycle. A result is consumed on every cycle where both `res_valid` and `res_ready` are high, whether or not it leads to a write.

Top module: `result_block_mover`

## Requirements
- R1: While the mover is idle and `cfg_count` is 0, accepted results produce no write and no done pulse.
- R2: Address bit 0 of every write is 0, whatever `cfg_base[0]` holds. Within a pass, successive writes step the address by 2, modulo 2^ADDR_W.
- R3: With `cfg_two_blk`=0 and count n, one pass writes base, base+2, …, base+2n−2.
- R4: With `cfg_two_blk`=1 and count n, the first block covers base … base+2n−2 and the second block covers base+2n … base+4n−2. The second block follows the first directly.
- R5: With `cfg_continuous`=1, the write after the last word of a pass goes back to the base address.
- R6: `fill_sel` changes only together with a done pulse. It is 0 when the first (or only) block has just been filled and 1 when the second block has. It resets to 0.
- R7: `blk_done` is high for one cycle, together with the write of the last word of each block, and at no other time.
- R8: A result accepted at clock edge t produces `wr_en`=1 for exactly the cycle after edge t, with `wr_data` equal to that result unchanged. Each accepted result produces at most one write.
- R9: Changes to the count, layout, continuous option and base address during a run have no effect until the end of the current pass. In continuous mode, the values present at that point are taken for the next pass. A count of 0 seen there returns the mover to idle.
- R10: After a non-continuous pass ends, results are discarded with no write until `cfg_count` has been 0 for at least one clock edge.
- R11: During reset `wr_en`, `blk_done`, `fill_sel` and `res_ready` are 0. From the first edge after reset, `res_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_base | input | ADDR_W | Region base address (bit 0 ignored) |
| cfg_count | input | CNT_W | Words per block, 0 disables |
| cfg_two_blk | input | 1 | 1 selects the two-block layout |
| cfg_continuous | input | 1 | 1 wraps to the base after each pass |
| res_valid | input | 1 | Conversion result present |
| res_ready | output | 1 | Result accepted when high with res_valid |
| res_data | input | DATA_W | Conversion result word |
| wr_en | output | 1 | Write strobe, one cycle per word |
| wr_addr | output | ADDR_W | Write byte address, always even |
| wr_data | output | DATA_W | Write data |
| blk_done | output | 1 | Pulse with the last write of a block |
| fill_sel | output | 1 | Block filled most recently (0 first, 1 second) |

## Verification
A word or block counter that slips shows up at the write port on the very next strobe. The address is then off by two, or `blk_done` lands on the wrong word, or `fill_sel` names the wrong half. A wrong run state shows up as a write where none is due, or a missing one, at the first result after a pass ends or after the count is cleared. The bench sweeps every combination of layout and continuous option over several counts, including 1 and the maximum. It uses a base address near the top of the space, with its low bit set, so that the wrap of the address space and the ignored bit are both exercised.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef enum logic [1:0] {
    RBM_IDLE = 2'd0,
    RBM_RUN  = 2'd1,
    RBM_HOLD = 2'd2
  } rbm_state_e;
endpackage

// File: rtl/rbm_shadow.sv
module rbm_shadow #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             use_live,
  input  logic [CNT_W-1:0] live_cnt,
  input  logic             live_two,
  input  logic             live_cont,
  output logic [CNT_W-1:0] eff_cnt,
  output logic             eff_two,
  output logic             eff_cont
);
  logic [CNT_W-1:0] cnt_q;
  logic             two_q;
  logic             cont_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      two_q  <= 1'b0;
      cont_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= live_cnt;
      two_q  <= live_two;
      cont_q <= live_cont;
    end
  end

  // While idle the live settings steer the first word; afterwards the held copy.
  always_comb begin
    eff_cnt  = use_live ? live_cnt  : cnt_q;
    eff_two  = use_live ? live_two  : two_q;
    eff_cont = use_live ? live_cont : cont_q;
  end
endmodule

// File: rtl/rbm_seq.sv
module rbm_seq
  import rbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] live_base,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic [CNT_W-1:0]  eff_cnt,
  input  logic              eff_two,
  input  logic              eff_cont,
  output logic              load,
  output logic              use_live,
  output logic              wr_req,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              blk_end,
  output logic              fill_val
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  rbm_state_e       state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             blk_q, blk_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] base_even;
  logic             live_off;
  logic             last_word;
  logic             pass_end;

  assign base_even = {live_base[ADDR_W-1:1], 1'b0};
  assign live_off  = (live_cnt == '0);
  assign use_live  = (state_q == RBM_IDLE);
  assign cur_addr  = use_live ? base_even : addr_q;
  assign wr_req    = accept && ((state_q == RBM_RUN) ||
                                ((state_q == RBM_IDLE) && !live_off));
  assign last_word = (idx_q == (eff_cnt - CNT_W'(1)));
  assign pass_end  = last_word && (!eff_two || blk_q);
  assign blk_end   = wr_req && last_word;
  assign fill_val  = blk_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    blk_d   = blk_q;
    addr_d  = addr_q;
    load    = 1'b0;
    unique case (state_q)
      RBM_IDLE: begin
        load = 1'b1;
        if (wr_req) state_d = RBM_RUN;
      end
      RBM_HOLD: begin
        if (live_off) state_d = RBM_IDLE;
      end
      default: ;
    endcase
    if (wr_req) begin
      if (pass_end) begin
        idx_d = '0;
        blk_d = 1'b0;
        if (eff_cont) begin
          load    = 1'b1;
          addr_d  = base_even;
          state_d = live_off ? RBM_IDLE : RBM_RUN;
        end else begin
          state_d = RBM_HOLD;
        end
      end else if (last_word) begin
        idx_d  = '0;
        blk_d  = 1'b1;
        addr_d = cur_addr + STEP;
      end else begin
        idx_d  = idx_q + CNT_W'(1);
        addr_d = cur_addr + STEP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RBM_IDLE;
      idx_q   <= '0;
      blk_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      blk_q   <= blk_d;
      addr_q  <= addr_d;
    end
  end
endmodule

// File: rtl/rbm_wport.sv
module rbm_wport #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              blk_end,
  input  logic              fill_val,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              blk_done,
  output logic              fill_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      blk_done <= 1'b0;
      fill_sel <= 1'b0;
    end else begin
      wr_en    <= wr_req;
      blk_done <= blk_end;
      if (wr_req) begin
        wr_addr <= req_addr;
        wr_data <= req_data;
      end
      if (blk_end) fill_sel <= fill_val;
    end
  end
endmodule

// File: rtl/result_block_mover.sv
module result_block_mover #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_two_blk,
  input  logic              cfg_continuous,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              blk_done,
  output logic              fill_sel
);
  logic             accept;
  logic             load;
  logic             use_live;
  logic [CNT_W-1:0] eff_cnt;
  logic             eff_two;
  logic             eff_cont;
  logic             wr_req;
  logic [ADDR_W-1:0] cur_addr;
  logic             blk_end;
  logic             fill_val;

  always_ff @(posedge clk) begin
    if (!rst_n) res_ready <= 1'b0;
    else        res_ready <= 1'b1;
  end

  assign accept = res_valid && res_ready;

  rbm_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .use_live (use_live),
    .live_cnt (cfg_count),
    .live_two (cfg_two_blk),
    .live_cont(cfg_continuous),
    .eff_cnt  (eff_cnt),
    .eff_two  (eff_two),
    .eff_cont (eff_cont)
  );

  rbm_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .live_base(cfg_base),
    .live_cnt (cfg_count),
    .eff_cnt  (eff_cnt),
    .eff_two  (eff_two),
    .eff_cont (eff_cont),
    .load     (load),
    .use_live (use_live),
    .wr_req   (wr_req),
    .cur_addr (cur_addr),
    .blk_end  (blk_end),
    .fill_val (fill_val)
  );

  rbm_wport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wport (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .req_addr(cur_addr),
    .req_data(res_data),
    .blk_end (blk_end),
    .fill_val(fill_val),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .blk_done(blk_done),
    .fill_sel(fill_sel)
  );
endmodule

// File: rtl/rbm_chk.sv
module rbm_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic              res_ready,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              blk_done,
  input logic              fill_sel
);
  logic              seen_q;
  logic              prev_done_q;
  logic [ADDR_W-1:0] prev_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      prev_done_q <= 1'b0;
      prev_addr_q <= '0;
    end else if (wr_en) begin
      seen_q      <= 1'b1;
      prev_done_q <= blk_done;
      prev_addr_q <= wr_addr;
    end
  end

  p_even_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr[0] == 1'b0));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && seen_q && !prev_done_q) |-> (wr_addr == prev_addr_q + ADDR_W'(2)));

  p_write_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(res_valid && res_ready));

  p_done_with_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> wr_en);

  p_fill_moves_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_done |-> $stable(fill_sel));

  p_ready_after_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> res_ready);
endmodule

bind result_block_mover rbm_chk #(.ADDR_W(ADDR_W)) u_rbm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .blk_done (blk_done),
  .fill_sel (fill_sel)
);

// File: tb/test_result_block_mover.sv
`timescale 1ns/1ps
module test_result_block_mover;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [CW-1:0] cfg_count = '0;
  logic          cfg_two_blk = 1'b0;
  logic          cfg_continuous = 1'b0;
  logic          res_valid = 1'b0;
  logic          res_ready;
  logic [DW-1:0] res_data = '0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          blk_done;
  logic          fill_sel;

  always #2.5 clk = ~clk;

  result_block_mover #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_result_block_mover (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_count(cfg_count),
    .cfg_two_blk(cfg_two_blk), .cfg_continuous(cfg_continuous),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .blk_done(blk_done), .fill_sel(fill_sel)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Reference model state (0 idle, 1 run, 2 hold)
  int m_st = 0, m_base = 0, m_n = 0, m_blk = 0, m_idx = 0;
  bit m_two = 0, m_cont = 0, m_fill = 0;
  bit e_wr, e_done;
  int e_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic latch_live();
    m_base = int'(cfg_base) & 'hFFFE;
    m_n    = int'(cfg_count);
    m_two  = cfg_two_blk;
    m_cont = cfg_continuous;
    m_blk  = 0;
    m_idx  = 0;
  endtask

  // Expected effect of one clock edge, from the live inputs before the edge.
  task automatic model_step(input bit valid);
    e_wr = 0; e_done = 0; e_addr = 0;
    if (m_st == 2) begin
      if (cfg_count == 0) m_st = 0;
    end else begin
      if (m_st == 0 && valid && cfg_count != 0) begin
        latch_live();
        m_st = 1;
      end
      if (m_st == 1 && valid) begin
        e_wr   = 1;
        e_addr = (m_base + 2 * (m_blk * m_n + m_idx)) & 'hFFFF;
        if (m_idx == m_n - 1) begin
          e_done = 1;
          m_fill = m_blk[0];
          if (!m_two || m_blk == 1) begin
            if (m_cont) begin
              if (cfg_count == 0) m_st = 0;
              else latch_live();
            end else begin
              m_st = 2;
            end
          end else begin
            m_blk = 1;
            m_idx = 0;
          end
        end else begin
          m_idx++;
        end
      end
    end
  endtask

  task automatic observe(input string tag, input logic [DW-1:0] d);
    chk(wr_en == e_wr, tag, "wr_en", int'(wr_en), int'(e_wr));
    chk(blk_done == e_done, "R7", "blk_done", int'(blk_done), int'(e_done));
    chk(fill_sel == m_fill, "R6", "fill_sel", int'(fill_sel), int'(m_fill));
    if (e_wr && wr_en) begin
      chk(int'(wr_addr) == e_addr, tag, "wr_addr", int'(wr_addr), e_addr);
      chk(wr_data == d, "R8", "wr_data", int'(wr_data), int'(d));
    end
  endtask

  task automatic send(input string tag, input logic [DW-1:0] d);
    res_valid = 1'b1;
    res_data  = d;
    model_step(1'b1);
    @(posedge clk);
    @(negedge clk);
    res_valid = 1'b0;
    observe(tag, d);
  endtask

  task automatic tick();
    model_step(1'b0);
    @(posedge clk);
    @(negedge clk);
    observe("R8", '0);
  endtask

  task automatic run_cfg(input int n, input bit two, input bit cont,
                         input logic [AW-1:0] base, input int seed);
    int pass_len;
    string tag;
    pass_len = two ? 2 * n : n;
    tag = cont ? "R5" : (two ? "R4" : "R3");
    cfg_count = '0;
    tick();
    tick();
    cfg_base = base;
    cfg_two_blk = two;
    cfg_continuous = cont;
    send("R1", 16'(seed));                  // count 0 while idle: no write
    cfg_count = CW'(n);
    for (int k = 0; k < (cont ? 2 * pass_len + 1 : pass_len); k++) begin
      send(tag, 16'(seed * 977 + k * 31));
      if (k == 0) begin                    // R9: changes during a run are deferred
        cfg_base = base ^ 16'h0400;
        if (!cont) cfg_two_blk = ~two;
      end
    end
    if (cont) begin
      cfg_count = '0;                      // R9: zero count taken at pass end
      for (int k = 0; k < pass_len + 1 && m_st != 0; k++)
        send("R9", 16'(seed + k));
      send("R9", 16'hBEEF);
    end else begin
      send("R10", 16'hCAFE);               // R10: discarded while held
      send("R10", 16'hF00D);
    end
  endtask

  initial begin
    int seed = 1;
    int ns[5] = '{1, 2, 3, 7, 255};
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0, "R11", "reset wr_en", int'(wr_en), 0);
    chk(blk_done == 1'b0, "R11", "reset blk_done", int'(blk_done), 0);
    chk(fill_sel == 1'b0, "R11", "reset fill_sel", int'(fill_sel), 0);
    chk(res_ready == 1'b0, "R11", "reset res_ready", int'(res_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_ready == 1'b1, "R11", "res_ready", int'(res_ready), 1);
    for (int i = 0; i < 5; i++) begin
      for (int mode = 0; mode < 4; mode++) begin
        run_cfg(ns[i], mode[0], mode[1],
                (mode == 3) ? 16'hFFF1 : 16'(16'h2001 + i * 16'h0300), seed);
        seed++;
      end
    end
    // R2/R3 at an odd, wrapping base with continuous off after a continuous run
    run_cfg(4, 1'b0, 1'b0, 16'hFFFB, seed);
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule